// File: doc/BRIEF.md
# Privileged System Register Unit

This block holds the control registers (indices 0, 2, 3 and 4) and the two descriptor-table registers of a segmented, paged processor. It executes the privileged instructions that read and write them: table-register load and store, status-word load and store, move to control register, and single-page TLB invalidate. The decoder supplies an operation kind, the three-bit register field of the mode byte, the operand size, whether the operand is in memory, the protection state and the current privilege level. The operand arrives on a single 48-bit bus, which is either the memory image that was read or the register value.

Every result is registered and appears one clock after the operation is accepted. Results are a memory write image with a per-byte mask, a register write-back, a one-cycle general-protection fault, a full TLB flush request, a single-entry flush request with its linear address, and a one-cycle invalid-register report. The page invalidate keeps the unit busy. Address translation and memory timing belong to other blocks.

Top module: `sysreg_unit`

## Requirements
- R1: After reset, control registers 0, 2, 3 and 4 read 0. Both table bases read 0 and both table limits read 0xFFFF.
- R2: When `prot_mode`=1 and `cpl`!=0, a table load, status-word load, control-register move or page invalidate raises `gp_fault` for one cycle. It changes no register and produces no flush, no write and no busy period. Table stores and status-word stores never fault, and nothing faults when `prot_mode`=0.
- R3: With `op_kind`=0, `reg_fld` selects the operation: 0 global-table store, 1 interrupt-table store, 2 global-table load, 3 interrupt-table load, 4 status-word store, 5 invalid, 6 status-word load, 7 page invalidate. A table store drives `wr_en` with a 6-byte image: limit in `wr_data[15:0]` (bytes 0-1), base in `wr_data[47:16]` (bytes 2-5), `wr_mask`=6'b111111.
- R4: A table load takes the limit from `opnd[15:0]` and the base from `opnd[47:16]`. With `op32`=0 the upper 8 base bits are cleared. With `op32`=1 all 32 bits are kept.
- R5: A status-word load replaces only control register 0 bits 3:0 with `opnd[3:0]`, and bit 0 is forced to 1.
- R6: A status-word store with `mem_form`=1 writes control register 0 bits 15:0 to `wr_data[15:0]` with `wr_mask`=6'b000011. With `mem_form`=0 it drives `reg_wr`, and `reg_wdata` is those 16 bits zero-extended. `reg_wr_hi` equals `op32`.
- R7: With `op_kind`=1, `reg_fld` names the control register, which is loaded from `opnd[31:0]`. Indices 1, 5, 6 and 7 raise `bad_reg` for one cycle and write nothing.
- R8: A write to control register 0 raises `flush_all` only if bit 31 or bit 16 changes value.
- R9: Every write to control register 3 raises `flush_all`, even when the value is unchanged.
- R10: A page invalidate accepted at clock edge N pulses `flush_one` after edge N+24, with `flush_addr`=`opnd[31:0]`. `busy` is high after edges N through N+23, operations offered while busy are ignored, and the next operation can be accepted at edge N+25.
- R11: `reg_fld`=5 with `op_kind`=0 raises `bad_reg` and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation offered this cycle |
| op_kind | input | 1 | 0 = table/status group, 1 = move to control register |
| reg_fld | input | 3 | Mode-byte register field |
| op32 | input | 1 | 32-bit operand size |
| mem_form | input | 1 | Operand is in memory |
| prot_mode | input | 1 | Protected mode active |
| cpl | input | 2 | Current privilege level |
| opnd | input | 48 | Operand or memory read image |
| busy | output | 1 | Page invalidate in progress |
| gp_fault | output | 1 | General-protection fault pulse |
| bad_reg | output | 1 | Invalid register field pulse |
| wr_en | output | 1 | Memory write request pulse |
| wr_data | output | 48 | Memory write image |
| wr_mask | output | 6 | Byte enables of the write image |
| reg_wr | output | 1 | Register write-back pulse |
| reg_wr_hi | output | 1 | Write-back covers the upper 16 bits |
| reg_wdata | output | 32 | Register write-back data |
| flush_all | output | 1 | Full TLB flush request pulse |
| flush_one | output | 1 | Single-entry TLB flush pulse |
| flush_addr | output | 32 | Linear address for the single-entry flush |
| cr0 | output | 32 | Control register 0 |
| cr2 | output | 32 | Control register 2 |
| cr3 | output | 32 | Control register 3 |
| cr4 | output | 32 | Control register 4 |

## Verification
The bench loads control register 0 with values that change bit 16, bit 31, another bit, or no bit at all. A flush test that compared whole words would flush on the unrelated bit, and one that missed a bit would stay silent on it. A status-word load with bit 0 clear catches a design that lets the protection bit fall. A 16-bit table load with a full base catches a design that keeps the top byte. Faulting operations are issued at a nonzero privilege level and then read back through the store operations, which exposes any partial update. During a page invalidate a second operation is offered, and the flush edge is counted exactly, which exposes an off-by-one busy window.

// File: rtl/sysreg_unit.sv
module sysreg_unit #(
  parameter int INVAL_CYC = 25
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_valid,
  input  logic        op_kind,
  input  logic [2:0]  reg_fld,
  input  logic        op32,
  input  logic        mem_form,
  input  logic        prot_mode,
  input  logic [1:0]  cpl,
  input  logic [47:0] opnd,
  output logic        busy,
  output logic        gp_fault,
  output logic        bad_reg,
  output logic        wr_en,
  output logic [47:0] wr_data,
  output logic [5:0]  wr_mask,
  output logic        reg_wr,
  output logic        reg_wr_hi,
  output logic [31:0] reg_wdata,
  output logic        flush_all,
  output logic        flush_one,
  output logic [31:0] flush_addr,
  output logic [31:0] cr0,
  output logic [31:0] cr2,
  output logic [31:0] cr3,
  output logic [31:0] cr4
);
  localparam int CW = $clog2(INVAL_CYC) + 1;
  localparam logic [31:0] PG_BITS = 32'h8001_0000;

  logic [31:0] gbase, ibase;
  logic [15:0] glim, ilim;
  logic [CW-1:0] cnt;

  logic accept, priv_op, fault, go, cr_ok;
  logic [31:0] ld_base;

  assign busy    = cnt != '0;
  assign accept  = op_valid && !busy;
  assign priv_op = op_kind || reg_fld == 3'd2 || reg_fld == 3'd3 ||
                   reg_fld == 3'd6 || reg_fld == 3'd7;
  assign fault   = accept && prot_mode && cpl != 2'd0 && priv_op;
  assign go      = accept && !fault;
  assign cr_ok   = reg_fld == 3'd0 || reg_fld == 3'd2 ||
                   reg_fld == 3'd3 || reg_fld == 3'd4;
  assign ld_base = op32 ? opnd[47:16] : {8'h00, opnd[39:16]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cr0 <= '0; cr2 <= '0; cr3 <= '0; cr4 <= '0;
      gbase <= '0; ibase <= '0; glim <= 16'hFFFF; ilim <= 16'hFFFF;
      cnt <= '0; gp_fault <= 1'b0; bad_reg <= 1'b0;
      wr_en <= 1'b0; wr_data <= '0; wr_mask <= '0;
      reg_wr <= 1'b0; reg_wr_hi <= 1'b0; reg_wdata <= '0;
      flush_all <= 1'b0; flush_one <= 1'b0; flush_addr <= '0;
    end else begin
      gp_fault  <= fault;
      bad_reg   <= 1'b0;
      wr_en     <= 1'b0;
      reg_wr    <= 1'b0;
      flush_all <= 1'b0;
      flush_one <= 1'b0;
      if (busy) begin
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) flush_one <= 1'b1;
      end
      if (go && !op_kind) begin
        case (reg_fld)
          3'd0: begin wr_en <= 1'b1; wr_data <= {gbase, glim}; wr_mask <= 6'b111111; end
          3'd1: begin wr_en <= 1'b1; wr_data <= {ibase, ilim}; wr_mask <= 6'b111111; end
          3'd2: begin gbase <= ld_base; glim <= opnd[15:0]; end
          3'd3: begin ibase <= ld_base; ilim <= opnd[15:0]; end
          3'd4: begin
            if (mem_form) begin
              wr_en <= 1'b1; wr_data <= {32'h0, cr0[15:0]}; wr_mask <= 6'b000011;
            end else begin
              reg_wr <= 1'b1; reg_wr_hi <= op32; reg_wdata <= {16'h0, cr0[15:0]};
            end
          end
          3'd6: cr0[3:0] <= opnd[3:0] | 4'h1;
          3'd7: begin cnt <= CW'(INVAL_CYC - 1); flush_addr <= opnd[31:0]; end
          default: bad_reg <= 1'b1;
        endcase
      end
      if (go && op_kind) begin
        if (!cr_ok) bad_reg <= 1'b1;
        else case (reg_fld)
          3'd0: begin
            cr0 <= opnd[31:0];
            flush_all <= ((cr0 ^ opnd[31:0]) & PG_BITS) != '0;
          end
          3'd2: cr2 <= opnd[31:0];
          3'd3: begin cr3 <= opnd[31:0]; flush_all <= 1'b1; end
          default: cr4 <= opnd[31:0];
        endcase
      end
    end
  end
endmodule

// File: rtl/sysreg_unit_chk.sv
module sysreg_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        gp_fault,
  input logic        bad_reg,
  input logic        wr_en,
  input logic        reg_wr,
  input logic        flush_all,
  input logic        flush_one,
  input logic [31:0] cr0,
  input logic [31:0] cr2,
  input logic [31:0] cr3,
  input logic [31:0] cr4
);
  AST_FAULT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    gp_fault |-> ($stable(cr0) && $stable(cr2) && $stable(cr3) && $stable(cr4))); // R2
  AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    gp_fault |-> (!flush_all && !flush_one && !wr_en && !reg_wr && !busy)); // R2
  AST_PG_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (cr0[31] != $past(cr0[31]) || cr0[16] != $past(cr0[16])) |-> flush_all); // R8
  AST_CR3_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (cr3 != $past(cr3)) |-> flush_all); // R9
  AST_ONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    flush_one |-> !busy); // R10
  AST_RESULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({gp_fault, bad_reg, wr_en, reg_wr})); // R7
endmodule

bind sysreg_unit sysreg_unit_chk u_chk (.*);

// File: tb/sim_sysreg_unit.sv
module sim_sysreg_unit;
  logic clk = 0, rst_n = 0;
  logic op_valid = 0, op_kind = 0, op32 = 0, mem_form = 0, prot_mode = 0;
  logic [2:0] reg_fld = 0;
  logic [1:0] cpl = 0;
  logic [47:0] opnd = 0;
  logic busy, gp_fault, bad_reg, wr_en, reg_wr, reg_wr_hi, flush_all, flush_one;
  logic [47:0] wr_data;
  logic [5:0] wr_mask;
  logic [31:0] reg_wdata, flush_addr, cr0, cr2, cr3, cr4;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sysreg_unit u0 (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic op(bit k, bit [2:0] f, bit s32, bit mem, bit pm, bit [1:0] pl, logic [47:0] d);
    @(negedge clk);
    op_valid = 1; op_kind = k; reg_fld = f; op32 = s32; mem_form = mem;
    prot_mode = pm; cpl = pl; opnd = d;
    @(negedge clk);
    op_valid = 0;
  endtask

  task automatic t_reset;
    chk("R1 cr0", cr0, 0); chk("R1 cr2", cr2, 0);
    chk("R1 cr3", cr3, 0); chk("R1 cr4", cr4, 0);
    op(0, 0, 1, 1, 0, 0, 0);
    chk("R1 gdt image", wr_data, 48'h0000_0000_FFFF);
    chk("R3 mask", wr_mask, 6'h3F);
    op(0, 1, 1, 1, 0, 0, 0);
    chk("R1 idt image", wr_data, 48'h0000_0000_FFFF);
  endtask

  task automatic t_table;
    op(0, 2, 1, 1, 0, 0, 48'h1234_5678_0123);
    op(0, 0, 1, 1, 0, 0, 0);
    chk("R4 gdt 32-bit", wr_data, 48'h1234_5678_0123);
    chk("R3 wr_en", wr_en, 1);
    op(0, 3, 0, 1, 0, 0, 48'hAABB_CCDD_0456);
    op(0, 1, 1, 1, 0, 0, 0);
    chk("R4 idt 16-bit", wr_data, 48'h00BB_CCDD_0456);
  endtask

  task automatic t_msw;
    op(1, 0, 1, 0, 0, 0, 48'h0000_00F0);
    chk("R8 no flush", flush_all, 0);
    op(0, 6, 0, 1, 0, 0, 48'h0000_FFF2);
    chk("R5 lmsw", cr0, 32'h0000_00F3);
    op(0, 4, 0, 1, 0, 0, 0);
    chk("R6 smsw mem data", wr_data, 48'h00F3);
    chk("R6 smsw mem mask", wr_mask, 6'h03);
    op(1, 0, 1, 0, 0, 0, 48'h0001_00F0);
    chk("R8 bit16 flush", flush_all, 1);
    op(0, 6, 0, 0, 0, 0, 48'h0000_0000);
    chk("R5 pe forced", cr0, 32'h0001_00F1);
    op(0, 4, 1, 0, 0, 0, 0);
    chk("R6 smsw reg", reg_wdata, 32'h0000_00F1);
    chk("R6 reg_wr", reg_wr, 1);
    chk("R6 hi", reg_wr_hi, 1);
    op(0, 4, 0, 0, 0, 0, 0);
    chk("R6 hi 16", reg_wr_hi, 0);
  endtask

  task automatic t_flush;
    op(1, 0, 1, 0, 0, 0, 48'h0001_00F1);
    chk("R8 same value", flush_all, 0);
    op(1, 0, 1, 0, 0, 0, 48'h8001_00F1);
    chk("R8 bit31 flush", flush_all, 1);
    op(1, 0, 1, 0, 0, 0, 48'h8001_00D1);
    chk("R8 other bit", flush_all, 0);
    chk("R7 cr0", cr0, 32'h8001_00D1);
    op(1, 3, 1, 0, 0, 0, 48'h0000_1000);
    chk("R9 cr3 flush", flush_all, 1);
    op(1, 3, 1, 0, 0, 0, 48'h0000_1000);
    chk("R9 cr3 same", flush_all, 1);
    chk("R7 cr3", cr3, 32'h1000);
    op(1, 2, 1, 0, 0, 0, 48'h0000_BEEF);
    chk("R7 cr2", cr2, 32'hBEEF);
    chk("R7 cr2 no flush", flush_all, 0);
    op(1, 4, 1, 0, 0, 0, 48'h0000_0030);
    chk("R7 cr4", cr4, 32'h30);
  endtask

  task automatic t_badreg;
    op(1, 1, 1, 0, 0, 0, 48'h1111_1111);
    chk("R7 bad idx1", bad_reg, 1);
    op(1, 7, 1, 0, 0, 0, 48'h2222_2222);
    chk("R7 bad idx7", bad_reg, 1);
    chk("R7 cr0 kept", cr0, 32'h8001_00D1);
    op(0, 5, 1, 0, 0, 0, 48'h3333_3333);
    chk("R11 group 5", bad_reg, 1);
    chk("R11 no write", wr_en, 0);
  endtask

  task automatic t_priv;
    op(1, 3, 1, 0, 1, 3, 48'h0000_9000);
    chk("R2 fault", gp_fault, 1);
    chk("R2 cr3 kept", cr3, 32'h1000);
    chk("R2 no flush", flush_all, 0);
    op(0, 2, 1, 1, 1, 1, 48'hFFFF_FFFF_FFFF);
    chk("R2 lgdt fault", gp_fault, 1);
    op(0, 0, 1, 1, 1, 3, 0);
    chk("R2 store no fault", gp_fault, 0);
    chk("R2 gdt kept", wr_data, 48'h1234_5678_0123);
    op(0, 7, 1, 1, 1, 2, 48'h5000);
    chk("R2 invlpg fault no busy", busy, 0);
    op(1, 2, 1, 0, 0, 3, 48'h0000_0777);
    chk("R2 real mode ok", gp_fault, 0);
    chk("R2 real mode cr2", cr2, 32'h777);
    op(0, 6, 1, 0, 1, 0, 48'h0);
    chk("R2 cpl0 ok", gp_fault, 0);
  endtask

  task automatic t_invlpg;
    int n;
    op(0, 7, 1, 1, 0, 0, 48'hDEAD_B000);
    chk("R10 busy", busy, 1);
    op(1, 2, 1, 0, 0, 0, 48'h0000_0055);
    chk("R10 ignored", cr2, 32'h777);
    n = 2;
    while (!flush_one && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk("R10 flush edge", n, 24);
    chk("R10 addr", flush_addr, 32'hDEAD_B000);
    chk("R10 idle", busy, 0);
    op(1, 2, 1, 0, 0, 0, 48'h0000_0056);
    chk("R10 next accepted", cr2, 32'h56);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset(); t_table(); t_msw(); t_flush(); t_badreg(); t_priv(); t_invlpg();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule